// File: doc/BRIEF.md
# Gated Black-Level Clamp and Gain Steering

This block sits behind an 8-bit video converter, on the luma/composite path or on the chroma path. It turns each converted sample into two charge-pump commands. One command drives the capacitor that sets the black-level offset. The other drives the capacitor that sets the amplifier gain. An external timing source supplies two windows. The gain window covers the sync tip, and during it the bottom of sync is steered toward the underflow boundary. The clamp window covers the back porch, and during it the black level is steered toward a per-channel target code. A separate peak-white limiter, enabled by an active-low pin, pushes the gain down whenever a sample overflows, whether or not the gain window is open.

Each command is a source/sink direction bit plus a 2-bit magnitude class. The magnitude classes are zero, small (8 units), medium (54 units) and large (540 units). Samples arrive as a valid/ready stream. The block never applies back-pressure: `smp_ready` is always high, and a sample is taken on every clock edge where `smp_valid` is high. On a clock edge with no valid sample, both commands return to zero. Both windows must never be open together. If they are, the block silences both pumps for that cycle and latches an error flag that stays set until reset.

Top module: `yc_level_loop`

## Requirements
- R1: While `clamp_gate` is low, the clamp command registered for that sample is zero.
- R2: On the luma channel (`chan_chroma`=0) with `clamp_gate` high, the clamp target is code 64. A sample below 64, or one flagged `smp_under`, gives source/medium. A sample above 64, or one flagged `smp_over`, gives sink/medium. Exactly 64 gives zero.
- R3: On the chroma channel (`chan_chroma`=1) with `clamp_gate` high, the same rule applies with target code 128.
- R4: With `agc_gate` high and no peak-white action, a sample flagged `smp_under` gives gain source/small. Any other sample gives gain sink/small.
- R5: With `pw_en_n` low, a sample flagged `smp_over` (and not `smp_under`) gives gain source/large, whatever the state of `agc_gate`.
- R6: With `agc_gate` low and no peak-white action, the gain command is zero. This covers `pw_en_n` high, and also `pw_en_n` low with no overflow.
- R7: With `pw_en_n` high and `agc_gate` high, an overflowing sample gives gain sink/small.
- R8: In any cycle where `agc_gate` and `clamp_gate` are both high, both commands registered for that cycle are zero and `gate_overlap` rises. Once high, `gate_overlap` stays high until reset.
- R9: Commands appear on the outputs one clock edge after the sample is accepted. `smp_ready` is always 1. An edge with `smp_valid` low yields zero on both commands.
- R10: Encoding: a direction bit of 1 means source (positive current). The magnitude field is 0 for zero, 1 for 8 units, 2 for 54 units and 3 for 540 units. A zero magnitude always carries direction 0.
- R11: While `rst_n` is low, both commands are zero and `gate_overlap` is low. A new reset clears the latched overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample present this cycle |
| smp_ready | output | 1 | Always 1; the block takes every sample |
| smp_code | input | 8 | Converted sample code |
| smp_under | input | 1 | Sample is below code 0 |
| smp_over | input | 1 | Sample is above code 255 |
| chan_chroma | input | 1 | 0 = luma/composite target, 1 = chroma target |
| agc_gate | input | 1 | Sync-tip gain window |
| clamp_gate | input | 1 | Back-porch clamp window |
| pw_en_n | input | 1 | Peak-white limiter enable, active low |
| clamp_src | output | 1 | Clamp command direction, 1 = source |
| clamp_mag | output | 2 | Clamp command magnitude class |
| gain_src | output | 1 | Gain command direction, 1 = source |
| gain_mag | output | 2 | Gain command magnitude class |
| gate_overlap | output | 1 | Latched error: both windows were open together |

## Verification
Every result of this block is due exactly one rising edge after the inputs that produce it. This holds for both commands and for the overlap flag. The bench changes inputs on the falling edge. On the next falling edge it compares the outputs with an expectation it queued when it drove those inputs. Each comparison therefore covers one registered edge and no more. The expectation is computed as signed current values from the rules above and then compared with the decoded outputs. This also checks the encoding and the zero-sign rule. The overlap case is checked on its own cycle and on the cycle after it, to confirm the flag stays set, and a second reset confirms the flag clears.

// File: rtl/yc_level_pkg.sv
package yc_level_pkg;

  typedef enum logic [1:0] {
    MAG_ZERO   = 2'd0,
    MAG_SMALL  = 2'd1,
    MAG_MEDIUM = 2'd2,
    MAG_LARGE  = 2'd3
  } mag_e;

  typedef struct packed {
    logic src;
    mag_e mag;
  } pump_cmd_t;

  localparam pump_cmd_t CMD_IDLE = '{src: 1'b0, mag: MAG_ZERO};

endpackage

// File: rtl/yc_clamp_cmp.sv
module yc_clamp_cmp
  import yc_level_pkg::*;
#(
  parameter int DW       = 8,
  parameter int LUMA_T   = 64,
  parameter int CHROMA_T = 128
) (
  input  logic [DW-1:0] code,
  input  logic          under,
  input  logic          over,
  input  logic          chroma,
  input  logic          gate,
  output pump_cmd_t     cmd
);

  localparam int NCH = 2;
  localparam logic [DW-1:0] LUMA_CODE   = LUMA_T[DW-1:0];
  localparam logic [DW-1:0] CHROMA_CODE = CHROMA_T[DW-1:0];

  logic [NCH-1:0] below;
  logic [NCH-1:0] above;

  // One comparator pair per channel target; the select picks a pair.
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [DW-1:0] TGT = (g == 0) ? LUMA_CODE : CHROMA_CODE;
    assign below[g] = under | (~over & (code < TGT));
    assign above[g] = ~under & (over | (code > TGT));
  end

  always_comb begin
    cmd = CMD_IDLE;
    if (gate) begin
      if (below[chroma])      cmd = '{src: 1'b1, mag: MAG_MEDIUM};
      else if (above[chroma]) cmd = '{src: 1'b0, mag: MAG_MEDIUM};
    end
  end

endmodule

// File: rtl/yc_gain_cmp.sv
module yc_gain_cmp
  import yc_level_pkg::*;
(
  input  logic      under,
  input  logic      over,
  input  logic      agc_gate,
  input  logic      pw_en_n,
  output pump_cmd_t cmd
);

  logic peak_hit;
  assign peak_hit = ~pw_en_n & over & ~under;

  always_comb begin
    cmd = CMD_IDLE;
    if (peak_hit)      cmd = '{src: 1'b1, mag: MAG_LARGE};
    else if (agc_gate) cmd = under ? '{src: 1'b1, mag: MAG_SMALL}
                                   : '{src: 1'b0, mag: MAG_SMALL};
  end

endmodule

// File: rtl/yc_gate_guard.sv
module yc_gate_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic agc_gate,
  input  logic clamp_gate,
  output logic overlap_now,
  output logic overlap_seen
);

  assign overlap_now = agc_gate & clamp_gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overlap_seen <= 1'b0;
    else        overlap_seen <= overlap_seen | overlap_now;
  end

endmodule

// File: rtl/yc_level_loop.sv
module yc_level_loop
  import yc_level_pkg::*;
#(
  parameter int DW       = 8,
  parameter int LUMA_T   = 64,
  parameter int CHROMA_T = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [DW-1:0] smp_code,
  input  logic          smp_under,
  input  logic          smp_over,
  input  logic          chan_chroma,
  input  logic          agc_gate,
  input  logic          clamp_gate,
  input  logic          pw_en_n,
  output logic          clamp_src,
  output logic [1:0]    clamp_mag,
  output logic          gain_src,
  output logic [1:0]    gain_mag,
  output logic          gate_overlap
);

  pump_cmd_t clamp_nxt, gain_nxt;
  pump_cmd_t clamp_q, gain_q;
  logic      overlap_now;
  logic      accept;

  assign smp_ready = 1'b1;
  assign accept    = smp_valid & smp_ready;

  yc_clamp_cmp #(
    .DW(DW), .LUMA_T(LUMA_T), .CHROMA_T(CHROMA_T)
  ) u_clamp (
    .code   (smp_code),
    .under  (smp_under),
    .over   (smp_over),
    .chroma (chan_chroma),
    .gate   (clamp_gate),
    .cmd    (clamp_nxt)
  );

  yc_gain_cmp u_gain (
    .under    (smp_under),
    .over     (smp_over),
    .agc_gate (agc_gate),
    .pw_en_n  (pw_en_n),
    .cmd      (gain_nxt)
  );

  yc_gate_guard u_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .agc_gate     (agc_gate),
    .clamp_gate   (clamp_gate),
    .overlap_now  (overlap_now),
    .overlap_seen (gate_overlap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clamp_q <= CMD_IDLE;
      gain_q  <= CMD_IDLE;
    end else if (!accept || overlap_now) begin
      clamp_q <= CMD_IDLE;
      gain_q  <= CMD_IDLE;
    end else begin
      clamp_q <= clamp_nxt;
      gain_q  <= gain_nxt;
    end
  end

  assign clamp_src = clamp_q.src;
  assign clamp_mag = clamp_q.mag;
  assign gain_src  = gain_q.src;
  assign gain_mag  = gain_q.mag;

endmodule

// File: rtl/yc_level_loop_chk.sv
module yc_level_loop_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_valid,
  input logic       smp_under,
  input logic       smp_over,
  input logic       agc_gate,
  input logic       clamp_gate,
  input logic       pw_en_n,
  input logic       clamp_src,
  input logic [1:0] clamp_mag,
  input logic       gain_src,
  input logic [1:0] gain_mag,
  input logic       gate_overlap
);

  p_clamp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !clamp_gate |=> clamp_mag == 2'd0);

  p_agc_under_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && agc_gate && !clamp_gate && smp_under)
      |=> (gain_mag == 2'd1 && gain_src));

  p_peak_large_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !pw_en_n && smp_over && !smp_under && !(agc_gate && clamp_gate))
      |=> (gain_mag == 2'd3 && gain_src));

  p_overlap_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (agc_gate && clamp_gate)
      |=> (clamp_mag == 2'd0 && gain_mag == 2'd0 && gate_overlap));

  p_overlap_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gate_overlap |=> gate_overlap);

  p_no_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> (clamp_mag == 2'd0 && gain_mag == 2'd0));

  p_zero_sign_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((clamp_mag == 2'd0) |-> !clamp_src) and ((gain_mag == 2'd0) |-> !gain_src));

endmodule

bind yc_level_loop yc_level_loop_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .smp_valid    (smp_valid),
  .smp_under    (smp_under),
  .smp_over     (smp_over),
  .agc_gate     (agc_gate),
  .clamp_gate   (clamp_gate),
  .pw_en_n      (pw_en_n),
  .clamp_src    (clamp_src),
  .clamp_mag    (clamp_mag),
  .gain_src     (gain_src),
  .gain_mag     (gain_mag),
  .gate_overlap (gate_overlap)
);

// File: tb/tb_yc_level_loop.sv
module tb_yc_level_loop;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0, smp_ready;
  logic [7:0] smp_code = 8'd0;
  logic       smp_under = 1'b0, smp_over = 1'b0, chan_chroma = 1'b0;
  logic       agc_gate = 1'b0, clamp_gate = 1'b0, pw_en_n = 1'b1;
  logic       clamp_src, gain_src, gate_overlap;
  logic [1:0] clamp_mag, gain_mag;

  yc_level_loop dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_code(smp_code), .smp_under(smp_under), .smp_over(smp_over),
    .chan_chroma(chan_chroma), .agc_gate(agc_gate), .clamp_gate(clamp_gate),
    .pw_en_n(pw_en_n), .clamp_src(clamp_src), .clamp_mag(clamp_mag),
    .gain_src(gain_src), .gain_mag(gain_mag), .gate_overlap(gate_overlap)
  );

  int    checks = 0;
  int    fails  = 0;
  int    q_cl[$];
  int    q_gn[$];
  bit    q_ov[$];
  string q_tag[$];
  bit    model_seen = 1'b0;

  // Signed current from an encoded command; 9999 marks an illegal zero-with-source.
  function automatic int cur(logic s, logic [1:0] m);
    int v;
    case (m)
      2'd0:    v = 0;
      2'd1:    v = 8;
      2'd2:    v = 54;
      default: v = 540;
    endcase
    if (m == 2'd0 && s) return 9999;
    return s ? v : -v;
  endfunction

  task automatic check_pending();
    int  ac, ag, ec, eg;
    bit  eo;
    string t;
    if (q_cl.size() == 0) return;
    ec = q_cl.pop_front(); eg = q_gn.pop_front(); eo = q_ov.pop_front(); t = q_tag.pop_front();
    ac = cur(clamp_src, clamp_mag);
    ag = cur(gain_src, gain_mag);
    checks++;
    if (ac != ec || ag != eg || gate_overlap != eo) begin
      fails++;
      $display("FAIL %s clamp=%0d exp %0d gain=%0d exp %0d flag=%0d exp %0d",
               t, ac, ec, ag, eg, gate_overlap, eo);
    end
  endtask

  task automatic drive(bit v, int code, bit un, bit ov, bit ch, bit ag, bit cg, bit pwn, string tag);
    int  ec, eg, tgt;
    bit  both;
    @(negedge clk);
    check_pending();
    smp_valid = v; smp_code = code[7:0]; smp_under = un; smp_over = ov;
    chan_chroma = ch; agc_gate = ag; clamp_gate = cg; pw_en_n = pwn;
    both = ag && cg;
    tgt  = ch ? 128 : 64;
    ec = 0; eg = 0;
    if (v && !both) begin
      if (cg) begin
        if (un)              ec = 54;
        else if (ov)         ec = -54;
        else if (code < tgt) ec = 54;
        else if (code > tgt) ec = -54;
      end
      if (!pwn && ov && !un) eg = 540;
      else if (ag)           eg = un ? 8 : -8;
    end
    model_seen = model_seen | both;
    q_cl.push_back(ec); q_gn.push_back(eg); q_ov.push_back(model_seen); q_tag.push_back(tag);
  endtask

  task automatic idle_check(string tag);
    checks++;
    if (clamp_mag != 2'd0 || gain_mag != 2'd0 || clamp_src || gain_src || gate_overlap) begin
      fails++;
      $display("FAIL %s reset outputs cm=%0d gm=%0d flag=%0d exp all 0", tag, clamp_mag, gain_mag, gate_overlap);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_check("R11");
    rst_n = 1'b1;
    checks++;
    if (smp_ready !== 1'b1) begin
      fails++; $display("FAIL R9 ready=%0b exp 1", smp_ready);
    end

    // R1: clamp window closed
    drive(1, 10, 0, 0, 0, 0, 0, 1, "R1");
    drive(1, 200, 0, 0, 1, 0, 0, 1, "R1");
    // R2: luma target 64
    drive(1, 10, 0, 0, 0, 0, 1, 1, "R2");
    drive(1, 63, 0, 0, 0, 0, 1, 1, "R2");
    drive(1, 64, 0, 0, 0, 0, 1, 1, "R2");
    drive(1, 65, 0, 0, 0, 0, 1, 1, "R2");
    drive(1, 0, 1, 0, 0, 0, 1, 1, "R2");
    drive(1, 255, 0, 1, 0, 0, 1, 1, "R2");
    // R3: chroma target 128
    drive(1, 127, 0, 0, 1, 0, 1, 1, "R3");
    drive(1, 128, 0, 0, 1, 0, 1, 1, "R3");
    drive(1, 129, 0, 0, 1, 0, 1, 1, "R3");
    drive(1, 64, 0, 0, 1, 0, 1, 1, "R3");
    // R4: sync-tip gain window
    drive(1, 0, 1, 0, 0, 1, 0, 1, "R4");
    drive(1, 0, 0, 0, 0, 1, 0, 1, "R4");
    drive(1, 200, 0, 0, 0, 1, 0, 1, "R4");
    // R7: overflow with limiter off inside the gain window
    drive(1, 255, 0, 1, 0, 1, 0, 1, "R7");
    // R5: peak-white limiter
    drive(1, 255, 0, 1, 0, 0, 0, 0, "R5");
    drive(1, 255, 0, 1, 0, 1, 0, 0, "R5");
    drive(1, 255, 0, 1, 1, 0, 1, 0, "R5");
    // R6: gain quiet outside the window
    drive(1, 255, 0, 1, 0, 0, 0, 1, "R6");
    drive(1, 255, 0, 0, 0, 0, 0, 0, "R6");
    drive(1, 0, 1, 0, 0, 0, 0, 0, "R6");
    // R9: no valid sample
    drive(0, 10, 0, 0, 0, 0, 1, 1, "R9");
    drive(0, 0, 1, 0, 0, 1, 0, 1, "R9");
    drive(1, 10, 0, 0, 0, 0, 1, 1, "R9");

    // R10: mixed sweep, windows never overlapping
    for (int i = 0; i < 400; i++) begin
      int r = $urandom;
      int w = $urandom_range(0, 2);
      int k = $urandom_range(0, 5);
      drive(r[0] | r[1], r[15:8], k == 0, k == 1, r[2], w == 1, w == 2, r[3], "R10");
    end

    // R8: overlap silences both pumps and latches
    drive(1, 10, 0, 0, 0, 1, 1, 0, "R8");
    drive(1, 10, 0, 0, 0, 0, 1, 1, "R8");
    drive(1, 255, 0, 1, 0, 1, 0, 0, "R8");
    drive(0, 0, 0, 0, 0, 0, 0, 1, "R8");
    @(negedge clk);
    check_pending();

    // R11: reset clears the latched overlap
    rst_n = 1'b0;
    model_seen = 1'b0;
    repeat (2) @(negedge clk);
    idle_check("R11");
    rst_n = 1'b1;
    drive(1, 10, 0, 0, 0, 0, 1, 1, "R11");
    @(negedge clk);
    check_pending();
    summary();
  end

endmodule